// File: doc/BRIEF.md
# Latency-Bounded Hit Funnel

This block collects timestamped hit words from a set of TDC channels and merges them into a single valid/ready output stream. That stream feeds the payload of a serial link. Any number of channels may fire in the same cycle. Channels are split into fixed groups, and each group owns a small FIFO that can accept several words per cycle. A round-robin arbiter picks which group's oldest word goes into the output register next.

Words that wait too long lose their value downstream, so the block never delivers them late. When a word reaches the head of its group FIFO, the block computes its age against the current bunch-crossing count, modulo the orbit length of 3564. A word whose age exceeds a programmable limit is discarded instead of sent. Two saturating counters record the two kinds of loss: words dropped as too old, and words refused because their FIFO was full.

Top module: `hit_funnel`

## Requirements
- R1: A delivered word is bit-identical to the 25-bit word captured from its channel. Bits [11:0] of the word are the coarse bunch-crossing stamp. The other bits pass through without being interpreted.
- R2: When a group FIFO has room, every hit presented in a cycle is captured, including the case where all channels fire together. Each captured word is delivered exactly once.
- R3: Within one group, words leave in arrival order. Among hits arriving in the same cycle, the lower channel index goes first.
- R4: When more than one group has a deliverable head, grants rotate round-robin. Two consecutive deliveries never come from the same group while the other group still has a deliverable word.
- R5: The age of a head word is (current count − stamp) mod 3564. A word whose age is greater than the limit is discarded. A word whose age equals the limit is delivered. A stamp that is ahead of the current count therefore counts as very old.
- R6: Each discarded old word increments the late counter by one. The counter saturates at its maximum value.
- R7: The free space in a group FIFO is measured before any removal in the same cycle. Hits beyond that space are refused, highest channel index first. Each refused hit increments the overflow counter, which saturates.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R9: After reset, out_valid_o is low, both counters read zero and all FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | NUM_CH | Per-channel hit strobe |
| hit_data_i | input | NUM_CH*25 | Per-channel hit words; channel c occupies bits [c*25 +: 25] |
| cur_bx_i | input | 12 | Current coarse count, 0..3563 |
| max_age_i | input | 12 | Largest age that is still delivered |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 25 | Output hit word |
| late_cnt_o | output | CNT_W | Saturating count of words discarded as too old |
| ovf_cnt_o | output | CNT_W | Saturating count of hits refused by a full FIFO |

## Verification
The bench targets the age boundary, the orbit wrap and the case where a stamp is ahead of the current count. A wrong comparison either delivers a word one crossing too old or drops one that is exactly at the limit. A subtraction without the modulo would throw away valid words near the wrap. The bench fills a FIFO while the output is stalled and then offers a full group in one cycle. A design that measured free space after that cycle's removal, or refused the wrong channels, would show a different overflow count or deliver the wrong survivor. A full eight-channel burst checks that groups interleave and that order within each group holds. A long run of late drops on a narrow counter exposes a counter that wraps instead of saturating.

// File: rtl/hit_funnel_pkg.sv
package hit_funnel_pkg;
  localparam int HIT_W     = 25;
  localparam int BX_W      = 12;
  localparam int BX_PERIOD = 3564;

  // modulo-orbit distance from stamp to now
  function automatic logic [BX_W-1:0] bx_age(input logic [BX_W-1:0] now,
                                             input logic [BX_W-1:0] stamp);
    logic [BX_W:0] t;
    if (now >= stamp) t = {1'b0, now} - {1'b0, stamp};
    else              t = {1'b0, now} + (BX_W+1)'(BX_PERIOD) - {1'b0, stamp};
    return t[BX_W-1:0];
  endfunction
endpackage

// File: rtl/hf_group_fifo.sv
module hf_group_fifo
  import hit_funnel_pkg::*;
#(
  parameter int GS    = 4,
  parameter int DEPTH = 4,
  localparam int OW   = $clog2(GS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [GS-1:0]            wr_valid_i,
  input  logic [GS-1:0][HIT_W-1:0] wr_data_i,
  input  logic                     pop_i,
  input  logic [BX_W-1:0]          cur_bx_i,
  input  logic [BX_W-1:0]          max_age_i,
  output logic                     head_ok_o,
  output logic                     head_late_o,
  output logic [HIT_W-1:0]         head_data_o,
  output logic [OW-1:0]            ovf_num_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(GS + DEPTH + 1);

  logic [HIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr_q, wr_ptr_q;
  logic [AW:0]      count_q;
  logic [CW-1:0]    acc, n_vld, free_c;
  logic [GS-1:0]    accept;
  logic [AW-1:0]    slot [GS];
  logic             empty, pop_eff;

  always_comb begin
    free_c = CW'(DEPTH) - CW'(count_q);
    acc    = '0;
    n_vld  = '0;
    accept = '0;
    for (int k = 0; k < GS; k++) begin
      slot[k] = wr_ptr_q + acc[AW-1:0];
      if (wr_valid_i[k]) begin
        n_vld = n_vld + CW'(1);
        if (acc < free_c) begin
          accept[k] = 1'b1;
          acc       = acc + CW'(1);
        end
      end
    end
  end

  assign ovf_num_o   = OW'(n_vld - acc);
  assign empty       = (count_q == '0);
  assign head_data_o = mem[rd_ptr_q];
  assign head_late_o = !empty && (bx_age(cur_bx_i, head_data_o[BX_W-1:0]) > max_age_i);
  assign head_ok_o   = !empty && !head_late_o;
  assign pop_eff     = head_late_o || (pop_i && head_ok_o);

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < GS; k++)
      if (accept[k]) mem[slot[k]] <= wr_data_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + acc[AW-1:0];
      rd_ptr_q <= rd_ptr_q + AW'(pop_eff);
      count_q  <= count_q + (AW+1)'(acc) - (AW+1)'(pop_eff);
    end
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= (AW+1)'(DEPTH));
  // R4
  pop_only_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_ok_o);
endmodule

// File: rtl/hf_rr_arb.sv
module hf_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q, enc;

  always_comb begin
    gnt_o = '0;
    enc   = last_q;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (req_i[idx] && gnt_o == '0) begin
        gnt_o[idx] = 1'b1;
        enc        = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  last_q <= IW'(N - 1);
    else if (adv_i && |gnt_o)     last_q <= enc;
  end

  // R4
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/hit_funnel.sv
module hit_funnel
  import hit_funnel_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int GRP_SIZE   = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         hit_valid_i,
  input  logic [NUM_CH*HIT_W-1:0]   hit_data_i,
  input  logic [BX_W-1:0]           cur_bx_i,
  input  logic [BX_W-1:0]           max_age_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [HIT_W-1:0]          out_data_o,
  output logic [CNT_W-1:0]          late_cnt_o,
  output logic [CNT_W-1:0]          ovf_cnt_o
);
  localparam int NUM_GRP = NUM_CH / GRP_SIZE;
  localparam int OW      = $clog2(GRP_SIZE + 1);

  logic [NUM_GRP-1:0]            head_ok, head_late, gnt, pop;
  logic [NUM_GRP-1:0][HIT_W-1:0] head_data;
  logic [NUM_GRP-1:0][OW-1:0]    ovf_num;
  logic [HIT_W-1:0]              sel_data;
  logic                          load;
  logic [CNT_W-1:0]              n_late, n_ovf;
  logic [CNT_W:0]                late_sum, ovf_sum;

  assign load = !out_valid_o || out_ready_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_SIZE-1:0][HIT_W-1:0] wdata;
    assign wdata  = hit_data_i[g*GRP_SIZE*HIT_W +: GRP_SIZE*HIT_W];
    assign pop[g] = gnt[g] && load;

    hf_group_fifo #(.GS(GRP_SIZE), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_valid_i  (hit_valid_i[g*GRP_SIZE +: GRP_SIZE]),
      .wr_data_i   (wdata),
      .pop_i       (pop[g]),
      .cur_bx_i    (cur_bx_i),
      .max_age_i   (max_age_i),
      .head_ok_o   (head_ok[g]),
      .head_late_o (head_late[g]),
      .head_data_o (head_data[g]),
      .ovf_num_o   (ovf_num[g])
    );
  end

  hf_rr_arb #(.N(NUM_GRP)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (head_ok),
    .adv_i  (load),
    .gnt_o  (gnt)
  );

  always_comb begin
    sel_data = '0;
    n_late   = '0;
    n_ovf    = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (gnt[g]) sel_data = sel_data | head_data[g];
      n_late = n_late + CNT_W'(head_late[g]);
      n_ovf  = n_ovf + CNT_W'(ovf_num[g]);
    end
    late_sum = {1'b0, late_cnt_o} + {1'b0, n_late};
    ovf_sum  = {1'b0, ovf_cnt_o} + {1'b0, n_ovf};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      late_cnt_o  <= '0;
      ovf_cnt_o   <= '0;
    end else begin
      if (load) begin
        out_valid_o <= |gnt;
        if (|gnt) out_data_o <= sel_data;
      end
      late_cnt_o <= late_sum[CNT_W] ? '1 : late_sum[CNT_W-1:0];
      ovf_cnt_o  <= ovf_sum[CNT_W]  ? '1 : ovf_sum[CNT_W-1:0];
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R5
  fresh_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && |gnt) |-> (bx_age(cur_bx_i, sel_data[BX_W-1:0]) <= max_age_i));
  // R6
  late_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 late_cnt_o >= $past(late_cnt_o));
  // R7
  ovf_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ovf_cnt_o >= $past(ovf_cnt_o));
endmodule

// File: tb/sim_hit_funnel.sv
`timescale 1ns/1ps
module sim_hit_funnel;
  localparam int NCH = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    hv = '0;
  logic [NCH*25-1:0] hd = '0;
  logic [11:0] cur_bx = '0, max_age = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [24:0] out_data;
  logic [CW-1:0] late_cnt, ovf_cnt;

  int checks = 0, failures = 0, cycles = 0;
  logic [24:0] got[$];

  always #2 clk = ~clk;

  hit_funnel #(.NUM_CH(NCH), .GRP_SIZE(4), .FIFO_DEPTH(4), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hit_valid_i(hv), .hit_data_i(hd),
    .cur_bx_i(cur_bx), .max_age_i(max_age), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data),
    .late_cnt_o(late_cnt), .ovf_cnt_o(ovf_cnt));

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_data);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [24:0] mk(int ch, int fine, int bx);
    return {8'(ch), 5'(fine), 12'(bx)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hv = '0; hd = '0; out_ready = 1'b0;
    wait_cyc(2);
    got.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(logic [NCH-1:0] mask, int fine, int bx);
    hv = mask;
    for (int c = 0; c < NCH; c++) hd[c*25 +: 25] = mk(c, fine, bx);
    @(negedge clk);
    hv = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 late_cnt", int'(late_cnt), 0);
    chk("R9 ovf_cnt", int'(ovf_cnt), 0);
  endtask

  task automatic t_single();
    do_reset();
    cur_bx = 200; max_age = 20; out_ready = 1'b1;
    push(8'h20, 7, 195);
    wait_cyc(6);
    chk("R1 count", got.size(), 1);
    if (got.size() == 1) chk("R1 word", int'(got[0]), int'(mk(5, 7, 195)));
  endtask

  task automatic t_burst();
    int n0;
    do_reset();
    cur_bx = 500; max_age = 30; out_ready = 1'b1;
    push(8'hFF, 3, 500);
    wait_cyc(14);
    chk("R2 all delivered", got.size(), 8);
    n0 = 0;
    foreach (got[i]) begin
      if (got[i][24:17] < 4) begin
        chk("R3 group0 order", int'(got[i][24:17]), n0);
        n0++;
      end
      if (i > 0) chk("R4 alternate", int'(got[i][24:17] / 4 != got[i-1][24:17] / 4), 1);
    end
  endtask

  task automatic t_order();
    do_reset();
    cur_bx = 40; max_age = 30; out_ready = 1'b1;
    push(8'h40, 1, 40);
    push(8'h10, 2, 40);
    wait_cyc(6);
    chk("R3 two-cycle count", got.size(), 2);
    if (got.size() == 2) begin
      chk("R3 first", int'(got[0]), int'(mk(6, 1, 40)));
      chk("R3 second", int'(got[1]), int'(mk(4, 2, 40)));
    end
  endtask

  task automatic t_backpressure();
    logic [24:0] held;
    do_reset();
    cur_bx = 900; max_age = 30; out_ready = 1'b0;
    push(8'h02, 9, 899);
    wait_cyc(3);
    chk("R8 valid", int'(out_valid), 1);
    held = out_data;
    chk("R8 word", int'(held), int'(mk(1, 9, 899)));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 stable", int'(out_valid && out_data == held), 1);
    end
    out_ready = 1'b1;
    wait_cyc(3);
    chk("R8 delivered once", got.size(), 1);
  endtask

  task automatic t_overflow();
    do_reset();
    cur_bx = 100; max_age = 50; out_ready = 1'b0;
    push(8'h0F, 0, 100);
    wait_cyc(4);
    push(8'h0F, 1, 100);
    wait_cyc(2);
    chk("R7 ovf count", int'(ovf_cnt), 3);
    out_ready = 1'b1;
    wait_cyc(12);
    chk("R7 delivered", got.size(), 5);
    if (got.size() == 5) begin
      for (int i = 0; i < 4; i++) chk("R7 first batch", int'(got[i]), int'(mk(i, 0, 100)));
      chk("R7 survivor", int'(got[4]), int'(mk(0, 1, 100)));
    end
  endtask

  task automatic t_late();
    do_reset();
    cur_bx = 100; max_age = 10; out_ready = 1'b1;
    push(8'h01, 0, 85);
    push(8'h02, 0, 90);
    push(8'h04, 0, 89);
    wait_cyc(6);
    chk("R6 late count", int'(late_cnt), 2);
    chk("R5 delivered", got.size(), 1);
    if (got.size() == 1) chk("R5 at limit", int'(got[0]), int'(mk(1, 0, 90)));
  endtask

  task automatic t_wrap();
    do_reset();
    cur_bx = 3; max_age = 10; out_ready = 1'b1;
    push(8'h10, 2, 3560);
    push(8'h20, 2, 3555);
    push(8'h40, 2, 5);
    wait_cyc(6);
    chk("R5 wrap late count", int'(late_cnt), 2);
    chk("R5 wrap delivered", got.size(), 1);
    if (got.size() == 1) chk("R5 wrap word", int'(got[0]), int'(mk(4, 2, 3560)));
  endtask

  task automatic t_sat();
    do_reset();
    cur_bx = 100; max_age = 10; out_ready = 1'b1;
    for (int i = 0; i < 10; i++) push(8'h11, 0, 50);
    wait_cyc(4);
    chk("R6 saturated", int'(late_cnt), 15);
    chk("R6 nothing sent", got.size(), 0);
    chk("R7 no overflow", int'(ovf_cnt), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_order();
    t_backpressure();
    t_overflow();
    t_late();
    t_wrap();
    t_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule